// File: doc/BRIEF.md
# Programmable-Bandwidth All-Digital PLL Core

This block holds the loop filter and frequency-correction parts of a first-order digital phase-locked loop that uses no analog components. Two phase detectors compare a reference input against a feedback input. One is an XOR type and one is edge-controlled, and each has its own output. The system wires one of them, outside the block, to the `cnt_down` direction input of an up/down loop counter. That counter runs on the K clock. A 4-bit bandwidth code sets its length and can be changed while the loop runs. A short counter gives wide bandwidth and fast lock. A long counter gives narrow bandwidth and slow lock.

Each wrap of the loop counter gives a one-cycle carry (counting up) or a one-cycle borrow (counting down). These events cross into the I/D clock domain. There they add or remove pulses in a stream that otherwise carries one pulse every second I/D clock. `id_out` acts as a count enable for an external divide-by-N counter, which runs on the I/D clock. The divider's output comes back as `fb_in`. With no corrections, the divider's output frequency is the I/D clock frequency divided by 2N.

Reset is synchronous and active high, and is sampled separately on each clock. Both clocks must therefore be running while it is held.

Top module: `dpll_core`

## Requirements
- R1: While `rst` is high, on every edge of both clocks, `xor_pd`, `ec_pd`, `k_carry`, `k_borrow` and `id_out` go low and the loop counter returns to zero.
- R2: `xor_pd` equals `ref_in` XOR `fb_in` as sampled at the third rising `k_clk` edge before the output is observed. A change of input driven between edges appears after the third following rising edge.
- R3: With `bw_sel` = 0 the loop counter holds its value and gives neither carry nor borrow, whatever `cnt_down` does.
- R4: With `bw_sel` = n (1..15) and `cnt_down` = 0 (count up), the counter has n+2 stages and modulus 2^(n+2). When the count equals 2^(n+2)-1 it wraps to 0 and `k_carry` is high for exactly one `k_clk` cycle. Counting up from zero, the first carry appears on the 2^(n+2)-th edge.
- R5: With `cnt_down` = 1 (count down), a count of 0 wraps to 2^(n+2)-1 and `k_borrow` is high for exactly one `k_clk` cycle. Counting down from zero, the first borrow appears on the first edge.
- R6: When `bw_sel` changes, the count keeps only the low n+2 bits that the new length holds, and counting continues from there.
- R7: A rising edge on `ref_in` sets `ec_pd`. A rising edge on `fb_in` clears it. Each is seen after the same three-edge sampling delay as R2. Falling edges, and repeated rising edges of the input that already acts, leave `ec_pd` unchanged. When both inputs rise together, `ec_pd` holds.
- R8: With no corrections pending, `id_out` is low on the first `id_clk` edge after reset and then alternates: one high cycle in every two.
- R9: Each carry adds exactly one `id_out` pulse, placed in an otherwise empty slot.
- R10: Each borrow removes exactly one `id_out` pulse from a slot that would otherwise have had one.
- R11: With `bw_sel` = 15 the counter is 17 stages long. Counting up from zero, there is no carry for 131071 edges and a carry on the 131072nd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k_clk | input | 1 | Loop counter and phase detector clock |
| id_clk | input | 1 | Increment/decrement clock |
| rst | input | 1 | Synchronous active-high reset, seen in both clock domains |
| ref_in | input | 1 | Reference signal, synchronized into the K domain |
| fb_in | input | 1 | Feedback from the external divide-by-N counter |
| bw_sel | input | 4 | Loop counter length code: 0 disables, n gives n+2 stages |
| cnt_down | input | 1 | Counter direction: 0 counts up, 1 counts down |
| xor_pd | output | 1 | XOR phase detector output |
| ec_pd | output | 1 | Edge-controlled phase detector output |
| k_carry | output | 1 | One-cycle carry pulse on up wrap |
| k_borrow | output | 1 | One-cycle borrow pulse on down wrap |
| id_out | output | 1 | Pulse stream, count enable for the external divider |

## Verification
The hardest situation to reach from the ports is a single isolated correction inside the I/D stream. Its effect is one extra or one missing pulse among many, and it appears at a point set by the synchronizer delay and the slot parity of an unrelated clock. The bench makes exactly one carry or one borrow by enabling the shortest counter length for an exact number of K clock edges and then setting the code back to zero. It counts `id_out` pulses over an even-length window of I/D clocks around that event. It then compares the count with half the window. Doing this makes the check independent of where the correction lands in time.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  // widest counter: largest code plus the fixed stage offset
  function automatic int cnt_width(input int sel_w, input int stage_ofs);
    return (1 << sel_w) - 1 + stage_ofs;
  endfunction

endpackage

// File: rtl/dpll_sync.sv
module dpll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/dpll_phase_det.sv
module dpll_phase_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  output logic xor_pd,
  output logic ec_pd
);
  logic ref_s, fb_s, ref_q, fb_q;
  logic ref_rise, fb_rise;

  dpll_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (.clk(clk), .rst(rst), .d(ref_in), .q(ref_s));
  dpll_sync #(.STAGES(SYNC_STAGES)) u_fb_sync  (.clk(clk), .rst(rst), .d(fb_in),  .q(fb_s));

  assign ref_rise = ref_s & ~ref_q;
  assign fb_rise  = fb_s  & ~fb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= 1'b0;
      fb_q   <= 1'b0;
      xor_pd <= 1'b0;
      ec_pd  <= 1'b0;
    end else begin
      ref_q  <= ref_s;
      fb_q   <= fb_s;
      xor_pd <= ref_s ^ fb_s;
      if (ref_rise && !fb_rise)      ec_pd <= 1'b1;
      else if (fb_rise && !ref_rise) ec_pd <= 1'b0;
    end
  end
endmodule

// File: rtl/dpll_kcounter.sv
module dpll_kcounter
  import dpll_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int STAGE_OFS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] bw_sel,
  input  logic             cnt_down,
  output logic             carry,
  output logic             borrow,
  output logic             carry_tgl,
  output logic             borrow_tgl
);
  localparam int CNT_W = cnt_width(SEL_W, STAGE_OFS);

  logic [CNT_W-1:0] cnt, mask, cur;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(bw_sel) + STAGE_OFS);
    cur = cnt & mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      carry      <= 1'b0;
      borrow     <= 1'b0;
      carry_tgl  <= 1'b0;
      borrow_tgl <= 1'b0;
    end else begin
      carry  <= 1'b0;
      borrow <= 1'b0;
      if (bw_sel != '0) begin
        if (dir_e'(cnt_down) == DIR_UP) begin
          if (cur == mask) begin
            cnt       <= '0;
            carry     <= 1'b1;
            carry_tgl <= ~carry_tgl;
          end else begin
            cnt <= cur + 1'b1;
          end
        end else begin
          if (cur == '0) begin
            cnt        <= mask;
            borrow     <= 1'b1;
            borrow_tgl <= ~borrow_tgl;
          end else begin
            cnt <= cur - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dpll_idpulse.sv
module dpll_idpulse #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic carry_tgl,
  input  logic borrow_tgl,
  output logic id_out
);
  logic c_s, b_s, c_q, b_q;
  logic pend_c, pend_b, slot;
  logic c_any, b_any;

  dpll_sync #(.STAGES(SYNC_STAGES)) u_c_sync (.clk(clk), .rst(rst), .d(carry_tgl),  .q(c_s));
  dpll_sync #(.STAGES(SYNC_STAGES)) u_b_sync (.clk(clk), .rst(rst), .d(borrow_tgl), .q(b_s));

  assign c_any = pend_c | (c_s ^ c_q);
  assign b_any = pend_b | (b_s ^ b_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q    <= 1'b0;
      b_q    <= 1'b0;
      pend_c <= 1'b0;
      pend_b <= 1'b0;
      slot   <= 1'b0;
      id_out <= 1'b0;
    end else begin
      c_q  <= c_s;
      b_q  <= b_s;
      slot <= ~slot;
      if (c_any && b_any) begin
        pend_c <= 1'b0;
        pend_b <= 1'b0;
        id_out <= slot;
      end else if (slot) begin
        id_out <= ~b_any;
        pend_b <= 1'b0;
        pend_c <= c_any;
      end else begin
        id_out <= c_any;
        pend_c <= 1'b0;
        pend_b <= b_any;
      end
    end
  end
endmodule

// File: rtl/dpll_core.sv
module dpll_core #(
  parameter int SEL_W       = 4,
  parameter int STAGE_OFS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             k_clk,
  input  logic             id_clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [SEL_W-1:0] bw_sel,
  input  logic             cnt_down,
  output logic             xor_pd,
  output logic             ec_pd,
  output logic             k_carry,
  output logic             k_borrow,
  output logic             id_out
);
  logic carry_tgl, borrow_tgl;

  dpll_phase_det #(.SYNC_STAGES(SYNC_STAGES)) u_pd (
    .clk(k_clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .xor_pd(xor_pd), .ec_pd(ec_pd)
  );

  dpll_kcounter #(.SEL_W(SEL_W), .STAGE_OFS(STAGE_OFS)) u_kcnt (
    .clk(k_clk), .rst(rst), .bw_sel(bw_sel), .cnt_down(cnt_down),
    .carry(k_carry), .borrow(k_borrow),
    .carry_tgl(carry_tgl), .borrow_tgl(borrow_tgl)
  );

  dpll_idpulse #(.SYNC_STAGES(SYNC_STAGES)) u_id (
    .clk(id_clk), .rst(rst), .carry_tgl(carry_tgl), .borrow_tgl(borrow_tgl),
    .id_out(id_out)
  );
endmodule

// File: rtl/dpll_core_chk.sv
module dpll_core_chk #(
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic             k_clk,
  input logic             rst,
  input logic             ref_in,
  input logic             fb_in,
  input logic [SEL_W-1:0] bw_sel,
  input logic             cnt_down,
  input logic             xor_pd,
  input logic             k_carry,
  input logic             k_borrow
);
  logic [3:0] age;

  always_ff @(posedge k_clk) begin
    if (rst)               age <= '0;
    else if (age != 4'hF)  age <= age + 4'd1;
  end

  // R3: a disabled counter is silent
  p_off_silent_r3: assert property (@(posedge k_clk) disable iff (rst)
    ($past(bw_sel) == '0) |-> !(k_carry || k_borrow));

  // R4: carries only while counting up and enabled
  p_carry_up_r4: assert property (@(posedge k_clk) disable iff (rst)
    k_carry |-> ($past(cnt_down) == 1'b0 && $past(bw_sel) != '0));

  // R4: carry lasts one cycle
  p_carry_single_r4: assert property (@(posedge k_clk) disable iff (rst)
    k_carry |=> !k_carry);

  // R5: borrows only while counting down and enabled
  p_borrow_down_r5: assert property (@(posedge k_clk) disable iff (rst)
    k_borrow |-> ($past(cnt_down) == 1'b1 && $past(bw_sel) != '0));

  // R5: borrow lasts one cycle, never together with carry
  p_borrow_single_r5: assert property (@(posedge k_clk) disable iff (rst)
    k_borrow |=> !k_borrow);

  p_no_both_r5: assert property (@(posedge k_clk) disable iff (rst)
    !(k_carry && k_borrow));

  // R2: XOR detector tracks inputs with fixed latency
  p_xor_latency_r2: assert property (@(posedge k_clk) disable iff (rst)
    (int'(age) > SYNC_STAGES + 1) |-> (xor_pd == $past(ref_in ^ fb_in, SYNC_STAGES + 1)));
endmodule

bind dpll_core dpll_core_chk #(.SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .k_clk(k_clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .bw_sel(bw_sel),
  .cnt_down(cnt_down), .xor_pd(xor_pd), .k_carry(k_carry), .k_borrow(k_borrow)
);

// File: tb/tb_dpll_core.sv
module tb_dpll_core;
  localparam int CLK_PERIOD = 10;
  localparam int ID_PERIOD  = 16;

  logic k_clk = 1'b0, id_clk = 1'b0, rst = 1'b1;
  logic ref_in = 1'b0, fb_in = 1'b0, cnt_down = 1'b0;
  logic [3:0] bw_sel = 4'd0;
  logic xor_pd, ec_pd, k_carry, k_borrow, id_out;

  int n_tests = 0, n_fail = 0;
  int idc = 0, pc = 0;
  int s_i, s_p;

  always #(CLK_PERIOD/2) k_clk = ~k_clk;
  always #(ID_PERIOD/2)  id_clk = ~id_clk;

  always @(negedge id_clk) begin
    idc <= idc + 1;
    if (id_out) pc <= pc + 1;
  end

  dpll_core dut (
    .k_clk(k_clk), .id_clk(id_clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .bw_sel(bw_sel), .cnt_down(cnt_down), .xor_pd(xor_pd), .ec_pd(ec_pd),
    .k_carry(k_carry), .k_borrow(k_borrow), .id_out(id_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step_k(input int n = 1);
    repeat (n) begin
      @(posedge k_clk);
      @(negedge k_clk);
    end
  endtask

  task automatic do_reset();
    @(negedge k_clk);
    rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0; bw_sel = 4'd0; cnt_down = 1'b0;
    step_k(6);
    rst = 1'b0;
  endtask

  task automatic win_start();
    @(posedge id_clk);
    s_i = idc; s_p = pc;
  endtask

  task automatic win_end(output int extra);
    repeat (30) @(posedge k_clk);
    @(posedge id_clk);
    while (((idc - s_i) % 2) != 0) @(posedge id_clk);
    extra = (pc - s_p) - (idc - s_i) / 2;
  endtask

  task automatic t_reset();
    @(negedge k_clk);
    rst = 1'b1; ref_in = 1'b1; fb_in = 1'b0; bw_sel = 4'd1; cnt_down = 1'b1;
    step_k(8);
    chk("R1", "xor_pd in reset", int'(xor_pd), 0);
    chk("R1", "ec_pd in reset", int'(ec_pd), 0);
    chk("R1", "k_borrow in reset", int'(k_borrow), 0);
    chk("R1", "k_carry in reset", int'(k_carry), 0);
    @(negedge id_clk);
    chk("R1", "id_out in reset", int'(id_out), 0);
  endtask

  task automatic t_xor();
    do_reset();
    ref_in = 1'b1;
    step_k(2);
    chk("R2", "xor before latency", int'(xor_pd), 0);
    step_k(1);
    chk("R2", "xor ref=1 fb=0", int'(xor_pd), 1);
    fb_in = 1'b1; step_k(3);
    chk("R2", "xor ref=1 fb=1", int'(xor_pd), 0);
    ref_in = 1'b0; step_k(3);
    chk("R2", "xor ref=0 fb=1", int'(xor_pd), 1);
    fb_in = 1'b0; step_k(3);
    chk("R2", "xor ref=0 fb=0", int'(xor_pd), 0);
  endtask

  task automatic t_ecpd();
    do_reset();
    ref_in = 1'b1; step_k(3);
    chk("R7", "ec set by ref rise", int'(ec_pd), 1);
    fb_in = 1'b1; step_k(3);
    chk("R7", "ec cleared by fb rise", int'(ec_pd), 0);
    fb_in = 1'b0; step_k(3);
    fb_in = 1'b1; step_k(3);
    chk("R7", "ec stays clear on second fb rise", int'(ec_pd), 0);
    ref_in = 1'b0; step_k(3);
    chk("R7", "ec ignores ref fall", int'(ec_pd), 0);
    ref_in = 1'b1; step_k(3);
    chk("R7", "ec set again", int'(ec_pd), 1);
    fb_in = 1'b0; step_k(3);
    chk("R7", "ec ignores fb fall", int'(ec_pd), 1);
    ref_in = 1'b0; step_k(3);
    ref_in = 1'b1; fb_in = 1'b1; step_k(3);
    chk("R7", "ec holds on simultaneous rises", int'(ec_pd), 1);
  endtask

  task automatic run_count(input string req, input logic [3:0] sel, input logic dn,
                           input int edges, input int exp_n, input int exp_first);
    int n, first;
    n = 0; first = 0;
    bw_sel = sel; cnt_down = dn;
    for (int i = 1; i <= edges; i++) begin
      step_k(1);
      if ((dn ? k_borrow : k_carry) == 1'b1) begin
        n++;
        if (first == 0) first = i;
      end
    end
    chk(req, "pulse count", n, exp_n);
    chk(req, "first pulse edge", first, exp_first);
  endtask

  task automatic t_disabled();
    int seen;
    do_reset();
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      cnt_down = i[2];
      step_k(1);
      if (k_carry || k_borrow) seen++;
    end
    chk("R3", "pulses while disabled", seen, 0);
    run_count("R3", 4'd1, 1'b0, 8, 1, 8);
  endtask

  task automatic t_modulus();
    do_reset();
    run_count("R4", 4'd1, 1'b0, 64, 8, 8);
    do_reset();
    run_count("R4", 4'd4, 1'b0, 128, 2, 64);
  endtask

  task automatic t_down();
    do_reset();
    run_count("R5", 4'd2, 1'b1, 40, 3, 1);
  endtask

  task automatic t_resize();
    do_reset();
    run_count("R6", 4'd3, 1'b0, 20, 0, 0);
    run_count("R6", 4'd1, 1'b0, 4, 1, 4);
  endtask

  task automatic t_idle_stream();
    int extra;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      @(posedge id_clk);
      @(negedge id_clk);
      chk("R8", "id_out alternation", int'(id_out), i % 2);
    end
    win_start();
    win_end(extra);
    chk("R8", "extra pulses with no corrections", extra, 0);
  endtask

  task automatic t_insert();
    int extra;
    do_reset();
    win_start();
    @(negedge k_clk);
    bw_sel = 4'd1; cnt_down = 1'b0;
    step_k(8);
    chk("R9", "carry made", int'(k_carry), 1);
    bw_sel = 4'd0;
    win_end(extra);
    chk("R9", "pulses added by one carry", extra, 1);
  endtask

  task automatic t_delete();
    int extra;
    do_reset();
    win_start();
    @(negedge k_clk);
    bw_sel = 4'd1; cnt_down = 1'b1;
    step_k(1);
    chk("R10", "borrow made", int'(k_borrow), 1);
    bw_sel = 4'd0;
    win_end(extra);
    chk("R10", "pulses removed by one borrow", extra, -1);
  endtask

  task automatic t_longest();
    do_reset();
    run_count("R11", 4'd15, 1'b0, 131072, 1, 131072);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_xor();
    t_ecpd();
    t_disabled();
    t_modulus();
    t_down();
    t_resize();
    t_idle_stream();
    t_insert();
    t_delete();
    t_longest();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule